// File: doc/BRIEF.md
# Synchronization-Aware Snooping Line Controller

This block is the snooping controller that one cache uses for one line. It tracks the line in the four MESI states and keeps three bits for every word of the line: a full/empty bit, a pending-read bit and a pending-write bit. Processor requests are ordinary reads and writes, plus synchronizing variants. A waiting read only completes on a full word. A waiting write only completes on an empty word and then fills it. An unconditional clear empties a word. An unconditional taking read reads a word and then empties it.

Synchronization misses are settled through the coherence protocol. Two extra bus transactions, a synchronizing write and a synchronizing clear, carry full/empty changes between caches. A wired-OR word-full line reports whether any cache holds the addressed word as full. A synchronization miss that cannot be settled is deferred. The controller then flags the deferral and records it in the pending bits of the addressed word.

Bus requests, the deferral flag, the flush flag and the snoop responses are combinational. They follow the current inputs and state. Line state and word bits update on the next clock edge. The shared and word-full response lines are sampled in the same cycle as the request they answer.

Top module: `fgs_snoop_ctrl`

## Requirements
- R1: After reset the line is Invalid (state code I=0, S=1, E=2, M=3). All word bits are 0, the taking read is idle, and no bus request, deferral or flush is driven.
- R2: An ordinary read (request code 0) in Invalid issues BusRd (bus code 0). The line goes to Shared if the sharing input is high and to Exclusive if it is low, and the word's full/empty bit takes the word-full input. A read in any valid state issues nothing.
- R3: An ordinary write (code 1) in Shared or Invalid issues BusRdX (bus code 1) and goes to Modified. In Exclusive it goes to Modified without bus traffic. In Modified it stays Modified.
- R4: A waiting read (code 2) in Invalid issues BusRd. If word-full is high, the line goes to Shared (sharing high) or Exclusive (sharing low), the word becomes full and its pending-read bit clears. Otherwise the controller defers, sets pending-read and stays Invalid. In a valid state, a full word is a hit with no bus traffic. An empty word is deferred with pending-read set and no bus request.
- R5: A waiting write (code 3) always issues BusSWr (bus code 2). In a valid state, an empty word becomes full, its pending-read bit clears and Exclusive moves to Shared. On a full word the controller defers and sets pending-write, and the state is kept. In Invalid, it defers and sets pending-write when word-full is high, and otherwise completes with no change.
- R6: An unconditional clear (code 4) on a full word in a valid state clears the full/empty and pending-write bits. Exclusive moves to Modified, Modified stays Modified, and Shared issues BusSCl (bus code 3). On an empty word or in Invalid it has no effect and issues nothing.
- R7: An unconditional taking read (code 5) acts as an ordinary read in its first cycle and raises busy_o. In the next cycle free of snoops it issues BusSCl for that word, clears the word's full/empty and pending-write bits and keeps the state. Processor requests are ignored while busy_o is high.
- R8: A snooped BusRd in Modified or Exclusive raises flush_o and moves the line to Shared. In Shared or Invalid it changes nothing.
- R9: A snooped BusRdX moves the line to Invalid from any state.
- R10: A snooped BusSWr on an empty word of a valid line sets the word full and clears its pending-read bit, and moves Modified or Exclusive to Shared. On a full word or an Invalid line it has no effect.
- R11: A snooped BusSCl on a full word of a valid line clears its full/empty and pending-write bits, and moves Modified or Exclusive to Shared. On an empty word it has no effect.
- R12: While snooping, snp_shared_o is high exactly when the line is valid. snp_full_o is high exactly when the line is valid and the snooped word is full.
- R13: A snoop takes priority. A processor request in the same cycle is ignored, and the second step of a taking read waits for a cycle without a snoop. No bus request or deferral is driven during a snoop.
- R14: Each transaction changes the bits of only the addressed word, selected by the word-select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 3 | Processor request code |
| req_word | input | WSEL | Word select of the request |
| bus_s_i | input | 1 | Wired-OR sharing response |
| bus_c_i | input | 1 | Wired-OR word-full response |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped bus code |
| snp_word | input | WSEL | Word select of the snooped transaction |
| bus_req_o | output | 1 | Bus transaction request |
| bus_op_o | output | 2 | Requested bus code |
| bus_word_o | output | WSEL | Word select of the request |
| defer_o | output | 1 | Synchronization miss deferred |
| flush_o | output | 1 | Line written back on a snooped read |
| snp_shared_o | output | 1 | Contribution to the sharing line |
| snp_full_o | output | 1 | Contribution to the word-full line |
| busy_o | output | 1 | Second step of a taking read pending |
| line_state_o | output | 2 | Line state code |
| fe_o | output | WORDS | Full/empty bits |
| pend_rd_o | output | WORDS | Pending-read bits |
| pend_wr_o | output | WORDS | Pending-write bits |

## Verification
The properties assume that snooped transactions and processor requests follow the stated codes. They also assume that the sharing and word-full responses are valid in the cycle of the request. The checker reads rst_n directly, so it assumes no stimulus arrives in the two cycles in which the internal reset is still releasing. The bench keeps every input at zero through reset and for several cycles afterwards. It drives only legal codes and changes inputs at the falling edge, so each request sees settled responses.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_t;
  typedef enum logic [2:0] {
    PR_READ = 3'd0, PR_WRITE = 3'd1, PR_WAIT_RD = 3'd2,
    PR_WAIT_WR = 3'd3, PR_CLEAR = 3'd4, PR_TAKE = 3'd5
  } preq_t;
  typedef enum logic [1:0] {BX_RD = 2'd0, BX_RDX = 2'd1, BX_SWR = 2'd2, BX_SCL = 2'd3} bxn_t;
  typedef struct packed {
    logic set_fe;
    logic clr_fe;
    logic set_prd;
    logic clr_prd;
    logic set_pwr;
    logic clr_pwr;
  } wupd_t;
endpackage

// File: rtl/fgs_decide.sv
module fgs_decide
  import fgs_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WSEL  = 2
) (
  input  line_t              cur,
  input  logic [WORDS-1:0]   fe,
  input  logic               busy,
  input  logic [WSEL-1:0]    busy_word,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [WSEL-1:0]    req_word,
  input  logic               s_in,
  input  logic               c_in,
  input  logic               snp_valid,
  input  logic [1:0]         snp_op,
  input  logic [WSEL-1:0]    snp_word,
  output line_t              nxt,
  output logic               bus_req,
  output bxn_t               bus_op,
  output logic [WSEL-1:0]    bus_word,
  output logic               defer,
  output logic               flush,
  output logic               upd,
  output logic [WSEL-1:0]    upd_word,
  output wupd_t              wu,
  output logic               busy_nxt,
  output logic [WSEL-1:0]    busy_word_nxt
);
  logic line_valid;
  logic owner;
  assign line_valid = (cur != LN_I);
  assign owner      = (cur == LN_E) || (cur == LN_M);

  always_comb begin
    nxt           = cur;
    bus_req       = 1'b0;
    bus_op        = BX_RD;
    bus_word      = req_word;
    defer         = 1'b0;
    flush         = 1'b0;
    upd           = 1'b0;
    upd_word      = req_word;
    wu            = '0;
    busy_nxt      = busy;
    busy_word_nxt = busy_word;
    if (snp_valid) begin
      upd_word = snp_word;
      case (bxn_t'(snp_op))
        BX_RD: if (owner) begin
          flush = 1'b1;
          nxt   = LN_S;
        end
        BX_RDX: nxt = LN_I;
        BX_SWR: if (line_valid && !fe[snp_word]) begin
          upd        = 1'b1;
          wu.set_fe  = 1'b1;
          wu.clr_prd = 1'b1;
          if (owner) nxt = LN_S;
        end
        default: if (line_valid && fe[snp_word]) begin
          upd        = 1'b1;
          wu.clr_fe  = 1'b1;
          wu.clr_pwr = 1'b1;
          if (owner) nxt = LN_S;
        end
      endcase
    end else if (busy) begin
      bus_req    = 1'b1;
      bus_op     = BX_SCL;
      bus_word   = busy_word;
      upd_word   = busy_word;
      upd        = 1'b1;
      wu.clr_fe  = 1'b1;
      wu.clr_pwr = 1'b1;
      busy_nxt   = 1'b0;
    end else if (req_valid) begin
      case (preq_t'(req_op))
        PR_READ, PR_TAKE: begin
          if (!line_valid) begin
            bus_req   = 1'b1;
            bus_op    = BX_RD;
            nxt       = s_in ? LN_S : LN_E;
            upd       = 1'b1;
            wu.set_fe = c_in;
            wu.clr_fe = !c_in;
          end
          if (preq_t'(req_op) == PR_TAKE) begin
            busy_nxt      = 1'b1;
            busy_word_nxt = req_word;
          end
        end
        PR_WRITE: begin
          if (cur == LN_E) nxt = LN_M;
          else if (cur != LN_M) begin
            bus_req = 1'b1;
            bus_op  = BX_RDX;
            nxt     = LN_M;
          end
        end
        PR_WAIT_RD: begin
          if (!line_valid) begin
            bus_req = 1'b1;
            bus_op  = BX_RD;
            upd     = 1'b1;
            if (c_in) begin
              nxt        = s_in ? LN_S : LN_E;
              wu.set_fe  = 1'b1;
              wu.clr_prd = 1'b1;
            end else begin
              defer      = 1'b1;
              wu.set_prd = 1'b1;
            end
          end else if (!fe[req_word]) begin
            defer      = 1'b1;
            upd        = 1'b1;
            wu.set_prd = 1'b1;
          end
        end
        PR_WAIT_WR: begin
          bus_req = 1'b1;
          bus_op  = BX_SWR;
          if (line_valid) begin
            upd = 1'b1;
            if (!fe[req_word]) begin
              wu.set_fe  = 1'b1;
              wu.clr_prd = 1'b1;
              if (cur == LN_E) nxt = LN_S;
            end else begin
              defer      = 1'b1;
              wu.set_pwr = 1'b1;
            end
          end else if (c_in) begin
            defer      = 1'b1;
            upd        = 1'b1;
            wu.set_pwr = 1'b1;
          end
        end
        PR_CLEAR: begin
          if (line_valid && fe[req_word]) begin
            upd        = 1'b1;
            wu.clr_fe  = 1'b1;
            wu.clr_pwr = 1'b1;
            if (cur == LN_E) nxt = LN_M;
            if (cur == LN_S) begin
              bus_req = 1'b1;
              bus_op  = BX_SCL;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fgs_word_bank.sv
module fgs_word_bank
  import fgs_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WSEL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [WSEL-1:0]  upd_word,
  input  wupd_t            wu,
  output logic [WORDS-1:0] fe,
  output logic [WORDS-1:0] prd,
  output logic [WORDS-1:0] pwr
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic en;
    logic fe_q, prd_q, pwr_q;
    logic fe_d, prd_d, pwr_d;

    assign en = upd && (upd_word == WSEL'(i));

    always_comb begin
      fe_d  = wu.set_fe  ? 1'b1 : (wu.clr_fe  ? 1'b0 : fe_q);
      prd_d = wu.set_prd ? 1'b1 : (wu.clr_prd ? 1'b0 : prd_q);
      pwr_d = wu.set_pwr ? 1'b1 : (wu.clr_pwr ? 1'b0 : pwr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fe_q  <= 1'b0;
        prd_q <= 1'b0;
        pwr_q <= 1'b0;
      end else if (en) begin
        fe_q  <= fe_d;
        prd_q <= prd_d;
        pwr_q <= pwr_d;
      end
    end

    assign fe[i]  = fe_q;
    assign prd[i] = prd_q;
    assign pwr[i] = pwr_q;
  end
endmodule

// File: rtl/fgs_snoop_ctrl.sv
module fgs_snoop_ctrl
  import fgs_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WSEL  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [WSEL-1:0]  req_word,
  input  logic             bus_s_i,
  input  logic             bus_c_i,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [WSEL-1:0]  snp_word,
  output logic             bus_req_o,
  output logic [1:0]       bus_op_o,
  output logic [WSEL-1:0]  bus_word_o,
  output logic             defer_o,
  output logic             flush_o,
  output logic             snp_shared_o,
  output logic             snp_full_o,
  output logic             busy_o,
  output logic [1:0]       line_state_o,
  output logic [WORDS-1:0] fe_o,
  output logic [WORDS-1:0] pend_rd_o,
  output logic [WORDS-1:0] pend_wr_o
);
  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  line_t           state_q, state_d;
  logic            busy_q, busy_d;
  logic [WSEL-1:0] bword_q, bword_d;
  bxn_t            bop;
  logic            upd;
  logic [WSEL-1:0] upd_word;
  wupd_t           wu;

  fgs_decide #(.WORDS(WORDS), .WSEL(WSEL)) u_decide (
    .cur(state_q), .fe(fe_o), .busy(busy_q), .busy_word(bword_q),
    .req_valid(req_valid), .req_op(req_op), .req_word(req_word),
    .s_in(bus_s_i), .c_in(bus_c_i),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_word(snp_word),
    .nxt(state_d), .bus_req(bus_req_o), .bus_op(bop), .bus_word(bus_word_o),
    .defer(defer_o), .flush(flush_o), .upd(upd), .upd_word(upd_word), .wu(wu),
    .busy_nxt(busy_d), .busy_word_nxt(bword_d)
  );

  fgs_word_bank #(.WORDS(WORDS), .WSEL(WSEL)) u_bank (
    .clk(clk), .rst_n(rst_q2), .upd(upd), .upd_word(upd_word), .wu(wu),
    .fe(fe_o), .prd(pend_rd_o), .pwr(pend_wr_o)
  );

  always_ff @(posedge clk or negedge rst_q2) begin
    if (!rst_q2) begin
      state_q <= LN_I;
      busy_q  <= 1'b0;
      bword_q <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      bword_q <= bword_d;
    end
  end

  assign bus_op_o     = bop;
  assign busy_o       = busy_q;
  assign line_state_o = state_q;
  assign snp_shared_o = snp_valid && (state_q != LN_I);
  assign snp_full_o   = snp_shared_o && fe_o[snp_word];
endmodule

// File: rtl/fgs_snoop_ctrl_chk.sv
module fgs_snoop_ctrl_chk #(
  parameter int WORDS = 4,
  parameter int WSEL  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [WSEL-1:0]  req_word,
  input logic             snp_valid,
  input logic [1:0]       snp_op,
  input logic             bus_req_o,
  input logic [1:0]       bus_op_o,
  input logic             defer_o,
  input logic             flush_o,
  input logic             busy_o,
  input logic [1:0]       line_state_o,
  input logic [WORDS-1:0] fe_o,
  input logic [WORDS-1:0] pend_rd_o
);
  logic accepted;
  assign accepted = req_valid && !snp_valid && !busy_o;

  p_snoop_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req_o && !defer_o));

  p_rdx_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd1) |=> (line_state_o == 2'd0));

  p_flush_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (line_state_o == 2'd1));

  p_one_word_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(fe_o ^ $past(fe_o)) <= 1));

  p_take_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !snp_valid) |-> (bus_req_o && bus_op_o == 2'd3));

  p_wait_wr_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_op == 3'd3) |-> (bus_req_o && bus_op_o == 2'd2));

  p_defer_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_op == 3'd2 && defer_o) |=> pend_rd_o[$past(req_word)]);
endmodule

bind fgs_snoop_ctrl fgs_snoop_ctrl_chk #(.WORDS(WORDS), .WSEL(WSEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_word(req_word), .snp_valid(snp_valid), .snp_op(snp_op),
  .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .defer_o(defer_o),
  .flush_o(flush_o), .busy_o(busy_o), .line_state_o(line_state_o),
  .fe_o(fe_o), .pend_rd_o(pend_rd_o)
);

// File: tb/tb_fgs_snoop_ctrl.sv
module tb_fgs_snoop_ctrl;
  localparam int WORDS = 4;
  localparam int WSEL  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [WSEL-1:0] req_word = '0;
  logic bus_s_i = 1'b0, bus_c_i = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_op = '0;
  logic [WSEL-1:0] snp_word = '0;
  logic bus_req_o, defer_o, flush_o, snp_shared_o, snp_full_o, busy_o;
  logic [1:0] bus_op_o, line_state_o;
  logic [WSEL-1:0] bus_word_o;
  logic [WORDS-1:0] fe_o, pend_rd_o, pend_wr_o;

  always #5 clk = ~clk;

  fgs_snoop_ctrl #(.WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_word(req_word), .bus_s_i(bus_s_i), .bus_c_i(bus_c_i),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_word(snp_word),
    .bus_req_o(bus_req_o), .bus_op_o(bus_op_o), .bus_word_o(bus_word_o),
    .defer_o(defer_o), .flush_o(flush_o), .snp_shared_o(snp_shared_o),
    .snp_full_o(snp_full_o), .busy_o(busy_o), .line_state_o(line_state_o),
    .fe_o(fe_o), .pend_rd_o(pend_rd_o), .pend_wr_o(pend_wr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       snp;
    logic [2:0] op;
    logic [1:0] w;
    logic       s;
    logic       c;
    logic       breq;
    logic [1:0] bop;
    logic       dfr;
    logic       fl;
    logic [1:0] st;
    logic [3:0] fe;
    logic [3:0] prd;
    logic [3:0] pwr;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,3'd2,2'd1,1'b0,1'b0, 1'b1,2'd0,1'b1,1'b0, 2'd0,4'b0000,4'b0010,4'b0000, 4'd4},  // R4 miss deferred
    '{1'b0,3'd2,2'd1,1'b0,1'b1, 1'b1,2'd0,1'b0,1'b0, 2'd2,4'b0010,4'b0000,4'b0000, 4'd4},  // R4 full elsewhere -> E
    '{1'b0,3'd3,2'd1,1'b0,1'b0, 1'b1,2'd2,1'b1,1'b0, 2'd2,4'b0010,4'b0000,4'b0010, 4'd5},  // R5 full word deferred
    '{1'b1,3'd3,2'd1,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd1,4'b0000,4'b0000,4'b0000, 4'd11}, // R11 snooped clear
    '{1'b0,3'd3,2'd2,1'b0,1'b0, 1'b1,2'd2,1'b0,1'b0, 2'd1,4'b0100,4'b0000,4'b0000, 4'd5},  // R5 empty word filled
    '{1'b0,3'd1,2'd0,1'b0,1'b0, 1'b1,2'd1,1'b0,1'b0, 2'd3,4'b0100,4'b0000,4'b0000, 4'd3},  // R3 S write
    '{1'b0,3'd3,2'd0,1'b0,1'b0, 1'b1,2'd2,1'b0,1'b0, 2'd3,4'b0101,4'b0000,4'b0000, 4'd5},  // R5 M stays M
    '{1'b0,3'd4,2'd2,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd3,4'b0001,4'b0000,4'b0000, 4'd6},  // R6 clear in M
    '{1'b1,3'd0,2'd0,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b1, 2'd1,4'b0001,4'b0000,4'b0000, 4'd8},  // R8 flush
    '{1'b0,3'd4,2'd0,1'b0,1'b0, 1'b1,2'd3,1'b0,1'b0, 2'd1,4'b0000,4'b0000,4'b0000, 4'd6},  // R6 clear in S
    '{1'b0,3'd4,2'd0,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd1,4'b0000,4'b0000,4'b0000, 4'd6},  // R6 empty no effect
    '{1'b1,3'd2,2'd3,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd1,4'b1000,4'b0000,4'b0000, 4'd10}, // R10 fill
    '{1'b1,3'd2,2'd3,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd1,4'b1000,4'b0000,4'b0000, 4'd10}, // R10 full ignored
    '{1'b0,3'd2,2'd2,1'b0,1'b0, 1'b0,2'd0,1'b1,1'b0, 2'd1,4'b1000,4'b0100,4'b0000, 4'd4},  // R4 valid empty defer
    '{1'b1,3'd2,2'd2,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd1,4'b1100,4'b0000,4'b0000, 4'd10}, // R10 clears pend-rd
    '{1'b1,3'd1,2'd0,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd0,4'b1100,4'b0000,4'b0000, 4'd9},  // R9
    '{1'b0,3'd0,2'd0,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0, 2'd1,4'b1100,4'b0000,4'b0000, 4'd2},  // R2 -> S
    '{1'b1,3'd1,2'd0,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd0,4'b1100,4'b0000,4'b0000, 4'd9},  // R9
    '{1'b0,3'd0,2'd0,1'b0,1'b1, 1'b1,2'd0,1'b0,1'b0, 2'd2,4'b1101,4'b0000,4'b0000, 4'd2},  // R2 -> E, fe from C
    '{1'b0,3'd1,2'd1,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd3,4'b1101,4'b0000,4'b0000, 4'd3},  // R3 E silent
    '{1'b0,3'd2,2'd3,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0, 2'd3,4'b1101,4'b0000,4'b0000, 4'd4}   // R4 hit
  };

  task automatic drive(input logic rv, input logic [2:0] op, input logic [1:0] w,
                       input logic s, input logic c,
                       input logic sv, input logic [1:0] sop, input logic [1:0] sw);
    @(negedge clk);
    req_valid = rv; req_op = op; req_word = w; bus_s_i = s; bus_c_i = c;
    snp_valid = sv; snp_op = sop; snp_word = sw;
    #2;
  endtask

  task automatic settle;
    @(posedge clk);
    #1;
  endtask

  task automatic regs(input string tag, input logic [1:0] st, input logic [3:0] fe,
                      input logic [3:0] prd, input logic [3:0] pwr);
    chk({tag, " state"}, 32'(line_state_o), 32'(st));
    chk({tag, " fe"}, 32'(fe_o), 32'(fe));
    chk({tag, " pend_rd"}, 32'(pend_rd_o), 32'(prd));
    chk({tag, " pend_wr"}, 32'(pend_wr_o), 32'(pwr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    regs("R1", 2'd0, 4'b0000, 4'b0000, 4'b0000);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 bus_req", 32'(bus_req_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic string tg = $sformatf("R%0d vec%0d", v.rq, i);
      drive(!v.snp, v.op, v.w, v.s, v.c, v.snp, v.op[1:0], v.w);
      chk({tg, " bus_req"}, 32'(bus_req_o), 32'(v.breq));
      if (v.breq) begin
        chk({tg, " bus_op"}, 32'(bus_op_o), 32'(v.bop));
        chk({tg, " bus_word"}, 32'(bus_word_o), 32'(v.w));
      end
      chk({tg, " defer"}, 32'(defer_o), 32'(v.dfr));
      chk({tg, " flush"}, 32'(flush_o), 32'(v.fl));
      settle();
      regs(tg, v.st, v.fe, v.prd, v.pwr);
    end
    // now M, fe 1101

    // R12 snoop responses; R10 full word ignored
    drive(0, 3'd0, 2'd0, 0, 0, 1, 2'd2, 2'd0);
    chk("R12 shared", 32'(snp_shared_o), 32'd1);
    chk("R12 full", 32'(snp_full_o), 32'd1);
    settle();
    regs("R10 full ignored", 2'd3, 4'b1101, 4'b0000, 4'b0000);
    drive(0, 3'd0, 2'd0, 0, 0, 1, 2'd3, 2'd1);
    chk("R12 empty word full", 32'(snp_full_o), 32'd0);
    settle();
    regs("R11 empty no effect", 2'd3, 4'b1101, 4'b0000, 4'b0000);

    // R13 coincident request ignored, snoop BusRd applied
    drive(1, 3'd4, 2'd0, 0, 0, 1, 2'd0, 2'd0);
    chk("R13 no bus", 32'(bus_req_o), 32'd0);
    chk("R8 flush", 32'(flush_o), 32'd1);
    settle();
    regs("R13 req dropped", 2'd1, 4'b1101, 4'b0000, 4'b0000);

    // R7 taking read on w2 in S
    drive(1, 3'd5, 2'd2, 0, 0, 0, 2'd0, 2'd0);
    chk("R7 hit no bus", 32'(bus_req_o), 32'd0);
    settle();
    chk("R7 busy", 32'(busy_o), 32'd1);
    drive(1, 3'd4, 2'd0, 0, 0, 0, 2'd0, 2'd0);
    chk("R7 scl req", 32'(bus_req_o), 32'd1);
    chk("R7 scl op", 32'(bus_op_o), 32'd3);
    chk("R7 scl word", 32'(bus_word_o), 32'd2);
    settle();
    regs("R7 word emptied, clear ignored", 2'd1, 4'b1001, 4'b0000, 4'b0000);
    chk("R7 busy done", 32'(busy_o), 32'd0);

    // R13 second step waits for snoop-free cycle
    drive(1, 3'd5, 2'd3, 0, 0, 0, 2'd0, 2'd0);
    settle();
    drive(0, 3'd0, 2'd0, 0, 0, 1, 2'd2, 2'd1);
    chk("R13 held", 32'(bus_req_o), 32'd0);
    settle();
    chk("R13 still busy", 32'(busy_o), 32'd1);
    regs("R13 snoop applied", 2'd1, 4'b1011, 4'b0000, 4'b0000);
    drive(0, 3'd0, 2'd0, 0, 0, 0, 2'd0, 2'd0);
    chk("R7 late scl", 32'(bus_op_o), 32'd3);
    chk("R7 late word", 32'(bus_word_o), 32'd3);
    settle();
    regs("R7 late clear", 2'd1, 4'b0011, 4'b0000, 4'b0000);

    // R5 waiting write in Invalid
    drive(0, 3'd0, 2'd0, 0, 0, 1, 2'd1, 2'd0);
    settle();
    drive(1, 3'd3, 2'd2, 0, 1, 0, 2'd0, 2'd0);
    chk("R5 inv swr", 32'(bus_op_o), 32'd2);
    chk("R5 inv defer", 32'(defer_o), 32'd1);
    settle();
    regs("R5 inv pend", 2'd0, 4'b0011, 4'b0000, 4'b0100);
    drive(1, 3'd3, 2'd2, 0, 0, 0, 2'd0, 2'd0);
    chk("R5 inv no defer", 32'(defer_o), 32'd0);
    settle();
    regs("R5 inv done", 2'd0, 4'b0011, 4'b0000, 4'b0100);

    // R6 clear in Invalid, R10 snoop fill in Invalid: no effect
    drive(1, 3'd4, 2'd0, 0, 0, 0, 2'd0, 2'd0);
    chk("R6 inv no bus", 32'(bus_req_o), 32'd0);
    settle();
    drive(0, 3'd0, 2'd0, 0, 0, 1, 2'd2, 2'd2);
    chk("R12 invalid shared", 32'(snp_shared_o), 32'd0);
    settle();
    regs("R6 R10 invalid unchanged", 2'd0, 4'b0011, 4'b0000, 4'b0100);

    // R4 waiting read in Invalid with S and C -> Shared
    drive(1, 3'd2, 2'd2, 1, 1, 0, 2'd0, 2'd0);
    chk("R4 busrd", 32'(bus_req_o), 32'd1);
    settle();
    regs("R4 shared fill", 2'd1, 4'b0111, 4'b0000, 4'b0100);

    // R1 reset mid-run
    drive(0, 3'd0, 2'd0, 0, 0, 0, 2'd0, 2'd0);
    rst_n = 1'b0;
    #1;
    regs("R1 mid reset", 2'd0, 4'b0000, 4'b0000, 4'b0000);
    chk("R1 mid busy", 32'(busy_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule